// File: doc/BRIEF.md
# Bus Bandwidth Monitor Counter

This block tallies the bytes that a set of observed memory ports move while each port's monitor is running. Each port presents a beat strobe and a byte count for that beat. A running monitor adds the count to its own byte counter. When the counter meets a programmable threshold, the monitor raises a sticky flag and can request an interrupt.

Software drives the block through a simple register bus. Reads return data one clock after the request. Each port owns a 4 KiB register window, and region 0 holds a shared global layer. The global layer keeps one status bit and one enable bit per port. A port's interrupt line asserts only when both its local enable and its global enable are set.

A build-time parameter picks the counter flavour. The wrap flavour returns the counter to zero each time it reaches the threshold. The overflow flavour keeps counting modulo 2^CNT_W and raises a separate overflow flag.

Top module: `bw_mon_top`

## Requirements
- R1: After reset, every counter, threshold, enable, local flag, global status and global enable is zero. `irq` is low and `bus_rdata` reads zero.
- R2: Bit 0 of a port's run register (offset 0x280) gates counting. While that bit is 0, beats are ignored and the counter keeps its value.
- R3: Writing a value with bit 0 set to a port's zero register (offset 0x284) resets that port's counter to zero. This wins over a beat accepted in the same cycle.
- R4: Each cycle a running port sees `beat_vld` high, its counter (read at offset 0x288) grows by that port's `beat_bytes`. Other ports are unaffected.
- R5: Status bit 0 (offset 0x100) is a sticky hit flag. In the overflow flavour it is set when the counter value after an update is greater than or equal to the threshold (offset 0x290), and the counter keeps counting past the threshold.
- R6: In the wrap flavour (WRAP_AT_THR=1), an update whose sum is greater than or equal to the threshold sets the hit flag and leaves the counter at zero. Status bit 1 is never set.
- R7: In the overflow flavour (WRAP_AT_THR=0), a sum that exceeds 2^CNT_W-1 leaves the counter at the sum modulo 2^CNT_W and sets sticky status bit 1.
- R8: A write to the interrupt clear register (offset 0x108) clears each status bit whose mask bit is 1 and leaves the others.
- R9: `irq[p]` is registered. It is high one cycle after port p has local interrupt enable bit 0 (offset 0x10C) set, global enable bit p set, and any status bit set.
- R10: Global status (region 0, offset 0x100) bit p is set whenever port p sets a local flag. Writing 1 at bit p of global clear (offset 0x108) clears it. Global enable sits at offset 0x10C, one bit per port.
- R11: Reads return the live value. Bits above a field read zero. Unmapped offsets and regions read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address: region in [ADDR_W-1:12] (0 is global, p+1 is port p), offset in [11:0] |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| beat_vld | input | NPORT | Per-port beat strobe |
| beat_bytes | input | NPORT*BYTES_W | Per-port byte count of the beat, port p in slice p |
| irq | output | NPORT | Per-port registered interrupt line |

## Verification
The bench builds two instances with NPORT=2, BYTES_W=8 and a 12-bit counter (CNT_W=12), one of each flavour. Both receive the same bus and beat stimulus, so a single sequence checks the wrap and the overflow behaviour side by side. The narrow counter lets seventeen 255-byte beats carry the counter past 2^12, which makes the modulo wrap and the overflow flag reachable within a few dozen cycles. With two ports, the bench can also check that one port's activity leaves the other port's counter and global status bit alone.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  // Local window offsets (per port) and global window offsets (region 0).
  localparam logic [11:0] OFF_ISTAT = 12'h100;
  localparam logic [11:0] OFF_ICLR  = 12'h108;
  localparam logic [11:0] OFF_IEN   = 12'h10C;
  localparam logic [11:0] OFF_RUN   = 12'h280;
  localparam logic [11:0] OFF_ZERO  = 12'h284;
  localparam logic [11:0] OFF_CNT   = 12'h288;
  localparam logic [11:0] OFF_THR   = 12'h290;

  typedef struct packed {
    logic ovf;
    logic hit;
  } bwm_flags_t;
endpackage

// File: rtl/bwm_chan.sv
module bwm_chan
  import bwm_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int BYTES_W     = 8,
  parameter int DATA_W      = 32,
  parameter bit WRAP_AT_THR = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [11:0]        wr_off,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [11:0]        rd_off,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               beat_vld,
  input  logic [BYTES_W-1:0] beat_bytes,
  output logic               irq_req,
  output logic               flag_evt
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_upd;
  logic [CNT_W-1:0] thr_q;
  logic             run_q, ie_q;
  bwm_flags_t       flags_q;
  logic [SUM_W-1:0] sum;
  logic             wr_run, wr_zero, wr_thr, wr_ie, wr_iclr, acc;
  logic             hit_set, ovf_set;

  assign wr_run  = wr_en && (wr_off == OFF_RUN);
  assign wr_zero = wr_en && (wr_off == OFF_ZERO) && wr_data[0];
  assign wr_thr  = wr_en && (wr_off == OFF_THR);
  assign wr_ie   = wr_en && (wr_off == OFF_IEN);
  assign wr_iclr = wr_en && (wr_off == OFF_ICLR);

  assign acc = beat_vld && run_q && !wr_zero;
  assign sum = SUM_W'(cnt_q) + SUM_W'(beat_bytes);

  generate
    if (WRAP_AT_THR) begin : g_wrap
      always_comb begin
        if (sum >= SUM_W'(thr_q)) begin
          cnt_upd = '0;
          hit_set = acc;
        end else begin
          cnt_upd = sum[CNT_W-1:0];
          hit_set = 1'b0;
        end
        ovf_set = 1'b0;
      end
    end else begin : g_ovf
      always_comb begin
        cnt_upd = sum[CNT_W-1:0];
        hit_set = acc && (sum[CNT_W-1:0] >= thr_q);
        ovf_set = acc && sum[CNT_W];
      end
    end
  endgenerate

  always_comb begin
    cnt_nxt = cnt_q;
    if (wr_zero)  cnt_nxt = '0;
    else if (acc) cnt_nxt = cnt_upd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      thr_q   <= '0;
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (wr_run) run_q <= wr_data[0];
      if (wr_ie)  ie_q  <= wr_data[0];
      if (wr_thr) thr_q <= wr_data[CNT_W-1:0];
      flags_q.hit <= (flags_q.hit && !(wr_iclr && wr_data[0])) || hit_set;
      flags_q.ovf <= (flags_q.ovf && !(wr_iclr && wr_data[1])) || ovf_set;
    end
  end

  always_comb begin
    unique case (rd_off)
      OFF_ISTAT: rd_data = DATA_W'(flags_q);
      OFF_IEN:   rd_data = DATA_W'(ie_q);
      OFF_RUN:   rd_data = DATA_W'(run_q);
      OFF_CNT:   rd_data = DATA_W'(cnt_q);
      OFF_THR:   rd_data = DATA_W'(thr_q);
      default:   rd_data = '0;
    endcase
  end

  assign irq_req  = ie_q && (flags_q.hit || flags_q.ovf);
  assign flag_evt = hit_set || ovf_set;

  // R2: a stopped monitor with no zero request keeps its count
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_zero) |=> $stable(cnt_q));

  // R3: zero request always leaves the counter at zero
  p_zero_wins_r3: assert property (@(posedge clk) disable iff (rst)
    wr_zero |=> (cnt_q == '0));

  // R7: overflow flag stays set until masked off
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flags_q.ovf && !(wr_iclr && wr_data[1])) |=> flags_q.ovf);

  // R5: hit flag stays set until masked off
  p_hit_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (flags_q.hit && !(wr_iclr && wr_data[0])) |=> flags_q.hit);

  generate
    if (WRAP_AT_THR) begin : g_wrap_chk
      // R6: a wrap-flavour update either returns to zero or never goes backwards
      p_wrap_mono_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && !wr_zero) |=> ((cnt_q == '0) || (cnt_q >= $past(cnt_q))));
    end
  endgenerate
endmodule

// File: rtl/bwm_glb.sv
module bwm_glb
  import bwm_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [11:0]       wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [11:0]       rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NPORT-1:0]  flag_evt,
  output logic [NPORT-1:0]  glb_en
);
  logic [NPORT-1:0] stat_q, en_q;
  logic             wr_clr, wr_en_reg;

  assign wr_clr    = wr_en && (wr_off == OFF_ICLR);
  assign wr_en_reg = wr_en && (wr_off == OFF_IEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_en_reg) en_q <= wr_data[NPORT-1:0];
      stat_q <= (stat_q & ~(wr_clr ? wr_data[NPORT-1:0] : '0)) | flag_evt;
    end
  end

  always_comb begin
    unique case (rd_off)
      OFF_ISTAT: rd_data = DATA_W'(stat_q);
      OFF_IEN:   rd_data = DATA_W'(en_q);
      default:   rd_data = '0;
    endcase
  end

  assign glb_en = en_q;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_chk
      // R10: a clear of bit p with no new event leaves bit p low
      p_glb_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && wr_data[p] && !flag_evt[p]) |=> !stat_q[p]);
      // R10: an event always marks the port
      p_glb_set_r10: assert property (@(posedge clk) disable iff (rst)
        flag_evt[p] |=> stat_q[p]);
    end
  endgenerate
endmodule

// File: rtl/bw_mon_top.sv
module bw_mon_top
  import bwm_pkg::*;
#(
  parameter int NPORT       = 4,
  parameter int CNT_W       = 32,
  parameter int BYTES_W     = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter bit WRAP_AT_THR = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NPORT-1:0]         beat_vld,
  input  logic [NPORT*BYTES_W-1:0] beat_bytes,
  output logic [NPORT-1:0]         irq
);
  localparam int REG_W = ADDR_W - 12;

  logic [REG_W-1:0]  region;
  logic [11:0]       off;
  logic [DATA_W-1:0] chan_rd [NPORT];
  logic [DATA_W-1:0] glb_rd, rd_sel;
  logic [NPORT-1:0]  irq_req, flag_evt, glb_en;

  assign region = bus_addr[ADDR_W-1:12];
  assign off    = bus_addr[11:0];

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_chan
      logic sel;
      assign sel = (region == REG_W'(p + 1));
      bwm_chan #(
        .CNT_W(CNT_W), .BYTES_W(BYTES_W), .DATA_W(DATA_W), .WRAP_AT_THR(WRAP_AT_THR)
      ) u_chan (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr && sel),
        .wr_off    (off),
        .wr_data   (bus_wdata),
        .rd_off    (off),
        .rd_data   (chan_rd[p]),
        .beat_vld  (beat_vld[p]),
        .beat_bytes(beat_bytes[p*BYTES_W +: BYTES_W]),
        .irq_req   (irq_req[p]),
        .flag_evt  (flag_evt[p])
      );
    end
  endgenerate

  bwm_glb #(.NPORT(NPORT), .DATA_W(DATA_W)) u_glb (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && (region == '0)),
    .wr_off  (off),
    .wr_data (bus_wdata),
    .rd_off  (off),
    .rd_data (glb_rd),
    .flag_evt(flag_evt),
    .glb_en  (glb_en)
  );

  always_comb begin
    rd_sel = (region == '0) ? glb_rd : '0;
    for (int p = 0; p < NPORT; p++)
      if (region == REG_W'(p + 1)) rd_sel = chan_rd[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_sel;
      irq <= irq_req & glb_en;
    end
  end

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_irq_chk
      // R9: a line only rises when the global enable was set the cycle before
      p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        irq[p] |-> $past(glb_en[p]));
    end
  endgenerate
endmodule

// File: tb/bw_mon_top_bench.sv
module bw_mon_top_bench;
  localparam int NPORT = 2, CNT_W = 12, BYTES_W = 8, ADDR_W = 16, DATA_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] rdata_o, rdata_w;
  logic [NPORT-1:0] beat_vld = '0;
  logic [NPORT*BYTES_W-1:0] beat_bytes = '0;
  logic [NPORT-1:0] irq_o, irq_w;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bw_mon_top #(.NPORT(NPORT), .CNT_W(CNT_W), .BYTES_W(BYTES_W), .ADDR_W(ADDR_W),
               .DATA_W(DATA_W), .WRAP_AT_THR(1'b0)) u_bw_mon_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_o), .beat_vld(beat_vld),
    .beat_bytes(beat_bytes), .irq(irq_o));

  bw_mon_top #(.NPORT(NPORT), .CNT_W(CNT_W), .BYTES_W(BYTES_W), .ADDR_W(ADDR_W),
               .DATA_W(DATA_W), .WRAP_AT_THR(1'b1)) u_bw_mon_top_wrap (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_w), .beat_vld(beat_vld),
    .beat_bytes(beat_bytes), .irq(irq_w));

  function automatic logic [15:0] pa(input int port, input logic [11:0] off);
    return 16'((port + 1) << 12) | 16'(off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] vo, output logic [31:0] vw);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; vo = rdata_o; vw = rdata_w;
  endtask

  task automatic beat(input logic [NPORT-1:0] m, input logic [7:0] b);
    @(negedge clk); beat_vld = m; beat_bytes = {NPORT{b}};
    @(negedge clk); beat_vld = '0;
  endtask

  task automatic t_reset;
    logic [31:0] o, w;
    chk("R1 irq ovf", 32'(irq_o), 0);
    chk("R1 irq wrap", 32'(irq_w), 0);
    chk("R1 rdata", rdata_o, 0);
    rd(pa(0, 12'h288), o, w); chk("R1 count ovf", o, 0); chk("R1 count wrap", w, 0);
    rd(pa(0, 12'h100), o, w); chk("R1 status", o | w, 0);
    rd(16'h0100, o, w); chk("R1 global status", o | w, 0);
  endtask

  task automatic t_accumulate;
    logic [31:0] o, w;
    beat(2'b01, 8'd50);
    rd(pa(0, 12'h288), o, w); chk("R2 stopped ignores beat", o, 0);
    wr(pa(0, 12'h290), 32'd1000);
    wr(pa(0, 12'h280), 32'h1);
    beat(2'b11, 8'd10); beat(2'b01, 8'd20); beat(2'b01, 8'd30);
    rd(pa(0, 12'h288), o, w); chk("R4 sum ovf", o, 60); chk("R4 sum wrap", w, 60);
    rd(pa(1, 12'h288), o, w); chk("R4 other port stopped", o, 0);
    wr(pa(0, 12'h280), 32'h0);
    beat(2'b01, 8'd40);
    rd(pa(0, 12'h288), o, w); chk("R2 held while stopped", o, 60);
  endtask

  task automatic t_zero;
    logic [31:0] o, w;
    wr(pa(0, 12'h284), 32'h1);
    rd(pa(0, 12'h288), o, w); chk("R3 zeroed", o, 0);
    wr(pa(0, 12'h280), 32'h1);
    beat(2'b01, 8'd25);
    rd(pa(0, 12'h288), o, w); chk("R4 after zero", o, 25);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = pa(0, 12'h284); bus_wdata = 32'h1;
    beat_vld = 2'b01; beat_bytes = {NPORT{8'd7}};
    @(negedge clk); bus_wr = 1'b0; beat_vld = '0;
    rd(pa(0, 12'h288), o, w); chk("R3 zero beats same-cycle beat", o, 0);
  endtask

  task automatic t_threshold;
    logic [31:0] o, w;
    wr(pa(0, 12'h290), 32'd100);
    beat(2'b01, 8'd60);
    rd(pa(0, 12'h100), o, w); chk("R5 below threshold", o | w, 0);
    beat(2'b01, 8'd60);
    rd(pa(0, 12'h288), o, w); chk("R5 ovf keeps count", o, 120); chk("R6 wrap to zero", w, 0);
    rd(pa(0, 12'h100), o, w); chk("R5 hit ovf", o, 1); chk("R6 hit wrap", w, 1);
    beat(2'b01, 8'd30);
    rd(pa(0, 12'h288), o, w); chk("R5 past threshold", o, 150); chk("R6 restart", w, 30);
    wr(pa(0, 12'h108), 32'h2);
    rd(pa(0, 12'h100), o, w); chk("R8 mask keeps hit", o, 1);
    wr(pa(0, 12'h108), 32'h1);
    rd(pa(0, 12'h100), o, w); chk("R8 hit cleared", o | w, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] o, w;
    wr(pa(0, 12'h284), 32'h1);
    wr(pa(0, 12'h290), 32'd4095);
    for (int i = 0; i < 17; i++) beat(2'b01, 8'd255);
    rd(pa(0, 12'h288), o, w); chk("R7 modulo count", o, 239); chk("R6 wrap count", w, 0);
    rd(pa(0, 12'h100), o, w); chk("R7 overflow flag", o, 2); chk("R6 no overflow flag", w, 1);
  endtask

  task automatic t_irq;
    logic [31:0] o, w;
    wr(pa(0, 12'h10C), 32'h1);
    @(negedge clk);
    chk("R9 global disabled", 32'(irq_o | irq_w), 0);
    wr(16'h010C, 32'h1);
    @(negedge clk);
    chk("R9 irq ovf", 32'(irq_o), 1); chk("R9 irq wrap", 32'(irq_w), 1);
    rd(16'h0100, o, w); chk("R10 global status", o, 1); chk("R10 global status wrap", w, 1);
    wr(16'h0108, 32'h1);
    rd(16'h0100, o, w); chk("R10 global cleared", o | w, 0);
    wr(pa(0, 12'h108), 32'h3);
    @(negedge clk);
    chk("R9 irq drops", 32'(irq_o | irq_w), 0);
  endtask

  task automatic t_map;
    logic [31:0] o, w;
    wr(pa(0, 12'h294), 32'd77);
    rd(pa(0, 12'h290), o, w); chk("R11 unmapped write ignored", o, 4095);
    rd(pa(0, 12'h294), o, w); chk("R11 unmapped reads zero", o, 0);
    wr(pa(1, 12'h280), 32'hFFFF_FFFF);
    rd(pa(1, 12'h280), o, w); chk("R11 upper bits zero", o, 1);
    wr(pa(1, 12'h290), 32'hFFFF_F123);
    rd(pa(1, 12'h290), o, w); chk("R11 threshold width", o, 32'h123);
    rd(16'h3288, o, w); chk("R11 unused region", o, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_accumulate();
    t_zero();
    t_threshold();
    t_overflow();
    t_irq();
    t_map();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule